// File: doc/BRIEF.md
# Debug run/step controller

This controller sits next to a small processor core and lets a host drive it through one command channel. The host can fill the program memory from address 0 upward, reset the core, execute a single instruction, let the program run until it stops, and read or write any memory word. While the host owns the memory port, the core's own memory traffic is blocked. While the core executes, host memory commands are held off.

Commands use a valid/ready handshake. The controller has no queue: `cmd_ready` is high only when nothing is in progress. The core side uses a one-cycle request pulse for each instruction and a retirement pulse that comes back when it finishes. Only one instruction is ever outstanding. A run stops when the core reports a halt at retirement. A run also stops when it has used its instruction budget of 1000; this is reported as a timeout, separate from a halt.

Top module: `dbg_exec_ctrl`

## Requirements
- R1: Op 5 (load first) writes `cmd_wdata` to address 0. Each following op 6 (load next) writes to the address after the previous load write. The address wraps from 255 to 0.
- R2: Op 3 (peek) gives `rsp_valid` high for one cycle, in the cycle after acceptance. `rsp_rdata` then holds the word stored at `cmd_addr`.
- R3: Op 4 (poke) stores `cmd_wdata` at `cmd_addr` in the acceptance cycle.
- R4: Op 0 (reset) produces exactly one `core_rst` pulse and clears `timed_out`. Memory contents are left unchanged.
- R5: Op 1 (step) on a core that is not stopped produces exactly one `core_step` pulse. `cmd_ready` returns high after the retirement.
- R6: Op 2 (run) keeps issuing instructions until one retires with `core_halted` high. It then sets `stopped` without setting `timed_out`.
- R7: A run that has not halted ends after exactly 1000 retired instructions and raises `timed_out`.
- R8: While `stopped` (core halted or timed out) is high, step and run are accepted but issue no `core_step`.
- R9: `cmd_ready` is low while an instruction is issued or outstanding, and during the peek response and reset cycles.
- R10: The memory port follows the core's request only while an instruction is issued or outstanding. Otherwise only host pokes and loads reach `mem_we`.
- R11: The instruction budget restarts at every run command, independent of earlier runs.
- R12: No new `core_step` is issued before the previous instruction has retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 3 | 0 reset, 1 step, 2 run, 3 peek, 4 poke, 5 load first, 6 load next, 7 no effect |
| cmd_addr | input | 8 | Word address for peek and poke |
| cmd_wdata | input | 32 | Data for poke and loads |
| rsp_valid | output | 1 | Peek data valid |
| rsp_rdata | output | 32 | Peek data |
| core_step | output | 1 | One-cycle request to execute one instruction |
| core_rst | output | 1 | One-cycle core reset (PC, flags, registers, stop) |
| core_retired | input | 1 | Instruction finished |
| core_halted | input | 1 | Core program stop status |
| core_mem_we | input | 1 | Core memory write enable |
| core_mem_addr | input | 8 | Core memory address |
| core_mem_wdata | input | 32 | Core memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after address (also fed to the core) |
| stopped | output | 1 | Halted or timed out; blocks execution |
| timed_out | output | 1 | Last run hit the instruction budget |

## Verification
The hardest case to reach is showing that the budget restarts at each run. The core must first run part of the budget, then be halted and reset, and then run a program that never halts. The bench's core model therefore takes a programmable halt index. It first halts after 300 instructions, and after a reset it never halts, so the second run must still count a full 1000 instructions. Retirement latency varies from 0 to 2 extra cycles, and core writes arrive at retirement. Spurious core writes are driven while the host owns memory, to show that they never reach the memory.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;

    localparam int MEM_AW = 8;
    localparam int MEM_DW = 32;

    typedef enum logic [2:0] {
        OP_RESET      = 3'd0,
        OP_STEP       = 3'd1,
        OP_RUN        = 3'd2,
        OP_PEEK       = 3'd3,
        OP_POKE       = 3'd4,
        OP_LOAD_FIRST = 3'd5,
        OP_LOAD_NEXT  = 3'd6,
        OP_NONE       = 3'd7
    } dbg_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CORE_RST,
        ST_PEEK,
        ST_ISSUE,
        ST_WAIT
    } dbg_state_e;

    typedef struct packed {
        logic              we;
        logic [MEM_AW-1:0] addr;
        logic [MEM_DW-1:0] data;
    } mem_req_t;

    function automatic logic op_is_load(dbg_op_e op);
        return (op == OP_LOAD_FIRST) || (op == OP_LOAD_NEXT);
    endfunction

    function automatic logic op_writes_mem(dbg_op_e op);
        return (op == OP_POKE) || op_is_load(op);
    endfunction

endpackage

// File: rtl/dbg_load_ptr.sv
module dbg_load_ptr
    import dbg_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic [MEM_AW-1:0] wr_addr
);
    logic [MEM_AW-1:0] ptr_q;

    // A restart writes at 0; otherwise at the running pointer.
    assign wr_addr = restart ? '0 : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (restart || advance) begin
            ptr_q <= wr_addr + MEM_AW'(1);
        end
    end
endmodule

// File: rtl/dbg_step_budget.sv
module dbg_step_budget #(
    parameter int STEP_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic at_edge
);
    localparam int CNT_W = $clog2(STEP_LIMIT + 1);
    localparam logic [CNT_W-1:0] EDGE_VAL = CNT_W'(STEP_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // High when the next retirement uses the last instruction of the budget.
    assign at_edge = (cnt_q == EDGE_VAL);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/dbg_mem_mux.sv
module dbg_mem_mux
    import dbg_ctrl_pkg::*;
(
    input  logic     core_own,
    input  mem_req_t host_req,
    input  mem_req_t core_req,
    output mem_req_t mem_req
);
    always_comb begin
        mem_req = core_own ? core_req : host_req;
    end
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_valid,
    input  dbg_op_e cmd_op,
    input  logic    core_retired,
    input  logic    core_halted,
    input  logic    budget_at_edge,
    output logic    cmd_ready,
    output logic    rsp_valid,
    output logic    core_step,
    output logic    core_rst,
    output logic    core_own,
    output logic    budget_clear,
    output logic    budget_tick,
    output logic    timeout
);
    dbg_state_e state_q, state_d;
    logic       run_q, run_d;
    logic       tmo_q, tmo_d;
    logic       accept;
    logic       blocked;

    assign accept  = cmd_valid && (state_q == ST_IDLE);
    assign blocked = core_halted || tmo_q;

    always_comb begin
        state_d      = state_q;
        run_d        = run_q;
        tmo_d        = tmo_q;
        budget_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (cmd_op)
                        OP_RESET: state_d = ST_CORE_RST;
                        OP_STEP: begin
                            if (!blocked) begin
                                state_d = ST_ISSUE;
                                run_d   = 1'b0;
                            end
                        end
                        OP_RUN: begin
                            if (!blocked) begin
                                state_d      = ST_ISSUE;
                                run_d        = 1'b1;
                                budget_clear = 1'b1;
                            end
                        end
                        OP_PEEK: state_d = ST_PEEK;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_CORE_RST: begin
                state_d = ST_IDLE;
                tmo_d   = 1'b0;
            end
            ST_PEEK:  state_d = ST_IDLE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (core_retired) begin
                    if (!run_q || core_halted) begin
                        state_d = ST_IDLE;
                    end else if (budget_at_edge) begin
                        state_d = ST_IDLE;
                        tmo_d   = 1'b1;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            run_q   <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            tmo_q   <= tmo_d;
        end
    end

    assign cmd_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = (state_q == ST_PEEK);
    assign core_step   = (state_q == ST_ISSUE);
    assign core_rst    = (state_q == ST_CORE_RST);
    assign core_own    = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    assign budget_tick = (state_q == ST_WAIT) && core_retired && run_q;
    assign timeout     = tmo_q;
endmodule

// File: rtl/dbg_exec_ctrl.sv
module dbg_exec_ctrl
    import dbg_ctrl_pkg::*;
#(
    parameter int STEP_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [MEM_AW-1:0] cmd_addr,
    input  logic [MEM_DW-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [MEM_DW-1:0] rsp_rdata,
    output logic              core_step,
    output logic              core_rst,
    input  logic              core_retired,
    input  logic              core_halted,
    input  logic              core_mem_we,
    input  logic [MEM_AW-1:0] core_mem_addr,
    input  logic [MEM_DW-1:0] core_mem_wdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic [MEM_DW-1:0] mem_rdata,
    output logic              stopped,
    output logic              timed_out
);
    dbg_op_e           op;
    logic              accept;
    logic              core_own;
    logic              budget_clear;
    logic              budget_tick;
    logic              budget_at_edge;
    logic [MEM_AW-1:0] load_addr;
    mem_req_t          host_req;
    mem_req_t          core_req;
    mem_req_t          out_req;

    assign op     = dbg_op_e'(cmd_op);
    assign accept = cmd_valid && cmd_ready;

    dbg_seq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_op         (op),
        .core_retired   (core_retired),
        .core_halted    (core_halted),
        .budget_at_edge (budget_at_edge),
        .cmd_ready      (cmd_ready),
        .rsp_valid      (rsp_valid),
        .core_step      (core_step),
        .core_rst       (core_rst),
        .core_own       (core_own),
        .budget_clear   (budget_clear),
        .budget_tick    (budget_tick),
        .timeout        (timed_out)
    );

    dbg_step_budget #(
        .STEP_LIMIT (STEP_LIMIT)
    ) u_budget (
        .clk     (clk),
        .rst     (rst),
        .clear   (budget_clear),
        .tick    (budget_tick),
        .at_edge (budget_at_edge)
    );

    dbg_load_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .restart (accept && (op == OP_LOAD_FIRST)),
        .advance (accept && (op == OP_LOAD_NEXT)),
        .wr_addr (load_addr)
    );

    always_comb begin
        host_req.we   = accept && op_writes_mem(op);
        host_req.addr = op_is_load(op) ? load_addr : cmd_addr;
        host_req.data = cmd_wdata;
        core_req.we   = core_mem_we;
        core_req.addr = core_mem_addr;
        core_req.data = core_mem_wdata;
    end

    dbg_mem_mux u_mux (
        .core_own (core_own),
        .host_req (host_req),
        .core_req (core_req),
        .mem_req  (out_req)
    );

    assign mem_we    = out_req.we;
    assign mem_addr  = out_req.addr;
    assign mem_wdata = out_req.data;
    assign rsp_rdata = mem_rdata;
    assign stopped   = core_halted || timed_out;
endmodule

// File: rtl/dbg_exec_ctrl_chk.sv
module dbg_exec_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [2:0] cmd_op,
    input logic       core_step,
    input logic       core_rst,
    input logic       core_retired,
    input logic       rsp_valid,
    input logic       stopped,
    input logic       timed_out,
    input logic       mem_we
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst || core_rst) pend_q <= 1'b0;
        else if (core_step) pend_q <= 1'b1;
        else if (core_retired) pend_q <= 1'b0;
    end

    a_r12_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        core_step |-> !pend_q);

    a_r5_step_is_pulse: assert property (@(posedge clk) disable iff (rst)
        core_step |=> !core_step);

    a_r9_no_ready_on_issue: assert property (@(posedge clk) disable iff (rst)
        core_step |-> !cmd_ready);

    a_r8_no_issue_when_stopped: assert property (@(posedge clk) disable iff (rst)
        core_step |-> !stopped);

    a_r4_core_rst_pulse: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> !core_rst);

    a_r4_rst_clears_timeout: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> !timed_out);

    a_r2_peek_response: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == 3'd3) |=> rsp_valid);

    a_r7_timeout_on_retire: assert property (@(posedge clk) disable iff (rst)
        $rose(timed_out) |-> $past(core_retired));

    a_r10_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && !cmd_valid) |-> !mem_we);
endmodule

bind dbg_exec_ctrl dbg_exec_ctrl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (cmd_op),
    .core_step    (core_step),
    .core_rst     (core_rst),
    .core_retired (core_retired),
    .rsp_valid    (rsp_valid),
    .stopped      (stopped),
    .timed_out    (timed_out),
    .mem_we       (mem_we)
);

// File: tb/test_dbg_exec_ctrl.sv
`timescale 1ns/1ps
module test_dbg_exec_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd7;
    logic [7:0]  cmd_addr = 8'd0;
    logic [31:0] cmd_wdata = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        core_step, core_rst, core_retired, core_halted;
    logic        core_mem_we;
    logic [7:0]  core_mem_addr;
    logic [31:0] core_mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        stopped, timed_out;

    int total = 0;
    int bad = 0;
    bit fin = 0;

    // behavioural core model
    logic inflight = 1'b0;
    int   lat_cnt = 0;
    int   lat_seed = 0;
    int   exec_n = 0;
    int   halt_at = 0;
    logic halted_q = 1'b0;
    logic junk_en = 1'b0;
    logic core_wr;

    // memory and reference state
    logic [31:0] mem [256];
    logic [31:0] ref_mem [256];
    int   ld_ptr = 0;
    int   pulses = 0;
    int   rst_pulses = 0;
    bit   host_wr;
    int   exp_addr;

    always #5 clk = ~clk;

    dbg_exec_ctrl i_dbg_exec_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .core_step(core_step), .core_rst(core_rst),
        .core_retired(core_retired), .core_halted(core_halted),
        .core_mem_we(core_mem_we), .core_mem_addr(core_mem_addr),
        .core_mem_wdata(core_mem_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .stopped(stopped), .timed_out(timed_out)
    );

    assign core_retired   = inflight && (lat_cnt == 0);
    assign core_halted    = halted_q || (core_retired && (exec_n + 1 == halt_at));
    assign core_wr        = core_retired && (exec_n % 2 == 0) && !junk_en;
    assign core_mem_we    = junk_en || core_wr;
    assign core_mem_addr  = junk_en ? 8'd100 : 8'(200 + exec_n % 8);
    assign core_mem_wdata = junk_en ? 32'hDEAD_0000 : 32'(exec_n + 32'h1000);

    always @(posedge clk) begin
        if (rst || core_rst) begin
            inflight <= 1'b0;
            lat_cnt  <= 0;
            exec_n   <= 0;
            halted_q <= 1'b0;
        end else if (core_step) begin
            inflight <= 1'b1;
            lat_cnt  <= lat_seed % 3;
            lat_seed <= lat_seed + 1;
        end else if (inflight) begin
            if (lat_cnt == 0) begin
                inflight <= 1'b0;
                exec_n   <= exec_n + 1;
                if (exec_n + 1 == halt_at) halted_q <= 1'b1;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    function automatic void chk(input bit ok, input string req,
                                input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // per-clock reference comparison
    always @(negedge clk) begin
        if (!rst && !fin) begin
            if (core_step) pulses++;
            if (core_rst) rst_pulses++;
            host_wr  = cmd_valid && cmd_ready && (cmd_op == 3'd4 || cmd_op == 3'd5 || cmd_op == 3'd6);
            exp_addr = (cmd_op == 3'd5) ? 0 : (cmd_op == 3'd6) ? ld_ptr : int'(cmd_addr);
            chk(mem_we == (host_wr || core_wr), "R10 mem_we", 32'(mem_we), 32'(host_wr || core_wr));
            if (host_wr) begin
                chk(mem_addr == 8'(exp_addr), "R1 R3 write address", 32'(mem_addr), 32'(exp_addr));
                chk(mem_wdata == cmd_wdata, "R3 write data", mem_wdata, cmd_wdata);
                ref_mem[exp_addr] = cmd_wdata;
                if (cmd_op != 3'd4) ld_ptr = (exp_addr + 1) % 256;
            end
            if (core_wr) begin
                chk(mem_addr == core_mem_addr, "R10 core address", 32'(mem_addr), 32'(core_mem_addr));
                ref_mem[core_mem_addr] = core_mem_wdata;
            end
            if (core_step) chk(!inflight, "R12 overlap", 32'(inflight), 32'd0);
            if (inflight) chk(!cmd_ready, "R9 ready while busy", 32'(cmd_ready), 32'd0);
        end
    end

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        while (!cmd_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = 3'd7;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic peek_chk(input logic [7:0] a, input string req);
        do_cmd(3'd3, a, 32'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b1, req, 32'(rsp_valid), 32'd1);
        chk(rsp_rdata == ref_mem[a], req, rsp_rdata, ref_mem[a]);
    endtask

    task automatic exec_cmd(input logic [2:0] op);
        pulses = 0;
        do_cmd(op, 8'd0, 32'd0);
        wait_idle();
    endtask

    task automatic core_reset(input string req);
        rst_pulses = 0;
        do_cmd(3'd0, 8'd0, 32'd0);
        wait_idle();
        chk(rst_pulses == 1, req, 32'(rst_pulses), 32'd1);
        chk(!timed_out && !stopped, req, {timed_out, stopped}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 32'd0;
            ref_mem[i] = 32'd0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !rsp_valid && !core_step && !core_rst, "R9 reset state",
            {cmd_ready, rsp_valid, core_step, core_rst}, 32'h8);
        chk(!stopped && !timed_out, "R8 reset status", {stopped, timed_out}, 32'd0);

        // R1: short load then readback
        do_cmd(3'd5, 8'd99, 32'h11);
        for (int i = 1; i < 4; i++) do_cmd(3'd6, 8'd99, 32'h11 + 32'(i));
        for (int i = 0; i < 4; i++) peek_chk(8'(i), "R1 R2 load readback");

        // R1: pointer wrap after 256 words
        do_cmd(3'd5, 8'd0, 32'hA000);
        for (int i = 1; i <= 256; i++) do_cmd(3'd6, 8'd0, 32'hA000 + 32'(i));
        chk(ref_mem[0] == 32'hA100, "R1 wrap model", ref_mem[0], 32'hA100);
        peek_chk(8'd0, "R1 wrap to 0");
        peek_chk(8'd255, "R1 last word");

        // R3 and R10: poke with the core spamming writes while idle
        junk_en = 1'b1;
        do_cmd(3'd4, 8'd77, 32'h7777_0001);
        do_cmd(3'd7, 8'd100, 32'h5);
        peek_chk(8'd77, "R3 poke");
        peek_chk(8'd100, "R10 idle core write blocked");
        junk_en = 1'b0;

        // R5: single step
        exec_cmd(3'd1);
        chk(pulses == 1, "R5 one instruction", 32'(pulses), 32'd1);

        // R6: run to a halt
        halt_at = 6;
        exec_cmd(3'd2);
        chk(pulses == 5, "R6 run until halt", 32'(pulses), 32'd5);
        chk(stopped && !timed_out, "R6 halt status", {stopped, timed_out}, 32'h2);

        // R8: blocked while halted
        exec_cmd(3'd1);
        chk(pulses == 0, "R8 step while halted", 32'(pulses), 32'd0);
        exec_cmd(3'd2);
        chk(pulses == 0, "R8 run while halted", 32'(pulses), 32'd0);

        // R4: reset keeps memory
        core_reset("R4 reset");
        peek_chk(8'd77, "R4 memory kept");

        // R11: partial run, then a full budget on the next run
        halt_at = 300;
        exec_cmd(3'd2);
        chk(pulses == 300, "R11 first run", 32'(pulses), 32'd300);
        core_reset("R4 reset after halt");
        halt_at = 0;
        exec_cmd(3'd2);
        chk(pulses == 1000, "R7 R11 budget", 32'(pulses), 32'd1000);
        chk(timed_out && stopped, "R7 timeout flag", {timed_out, stopped}, 32'h3);
        exec_cmd(3'd1);
        chk(pulses == 0, "R8 step after timeout", 32'(pulses), 32'd0);
        core_reset("R4 reset clears timeout");

        // R10: core writes made at retirement reach memory
        for (int i = 0; i < 8; i++) peek_chk(8'(200 + i), "R10 core write");

        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule